// File: doc/BRIEF.md
# Split-Read Timebase Counter

This block keeps a free-running 64-bit tick counter for measuring how long a stretch of work takes. A fractional prescaler advances the counter once every N core clocks. N may be a whole number or end in .5. It is programmed as twice its true value, so no fractions are involved. The counter can be preloaded, which lets a test start it just below a carry out of the low word.

Software sees the counter only as two 32-bit halves. A small reader engine assembles a consistent 64-bit value from them. It samples the upper half, then the lower half, then the upper half again, and repeats the whole sequence whenever the two upper samples differ. A request/acknowledge handshake returns the value. A busy flag stays high through every retry, and a saturating counter records how many retries have happened.

Two capture strobes latch start and end snapshots. An output turns their difference back into elapsed core cycles using the doubled divider.

Top module: `split_timebase`

## Requirements
- R1: Synchronous active-high reset clears the counter, the prescaler accumulator, both snapshots and the retry count. After reset, busy, acknowledge and elapsed read zero.
- R2: The doubled divider D2 (D2 >= 2) sets the tick rate. Each core clock adds 2 to an accumulator, and a tick is issued each time the accumulator reaches D2. n clocks after reset or a load, the counter holds its start value plus floor(2n/D2).
- R3: The upper 32-bit half increments exactly when the lower half wraps from all ones to zero. Otherwise it holds.
- R4: A read request taken while idle raises busy on the next cycle. The upper half, the lower half and the upper half are then sampled on three separate cycles. When the samples agree, acknowledge pulses for one cycle with busy low, three cycles after the request.
- R5: If the two upper samples differ, the three-step sequence repeats and busy stays high. Each retry adds three cycles before the acknowledge.
- R6: The returned value is never torn. Its upper 32 bits are the first upper sample of the final pass, and its lower 32 bits are the lower sample of that same pass. The value equals the counter as it stood one cycle before the final lower sample was taken.
- R7: Each retry increments the retry count, which saturates at all ones (255 at the default width).
- R8: A load strobe writes the 64-bit preload value into the counter and clears the prescaler accumulator on the same edge.
- R9: The start and stop strobes each capture the full 64-bit counter. Elapsed equals ((stop snapshot - start snapshot) * D2) >> 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| div2 | input | 16 | Doubled tick divider, at least 2 |
| load | input | 1 | Preload strobe |
| load_val | input | 64 | Preload value |
| rd_req | input | 1 | Read request, taken while idle |
| rd_ack | output | 1 | One-cycle read acknowledge |
| rd_busy | output | 1 | Read in progress, including retries |
| rd_data | output | 64 | Consistent 64-bit value |
| rd_retries | output | RETRY_W | Saturating retry count |
| cap_start | input | 1 | Capture start snapshot |
| cap_stop | input | 1 | Capture stop snapshot |
| elapsed | output | 64 | Elapsed core cycles between snapshots |

## Verification
If the prescaler accumulator drifts, the value returned by the very next read is off by one or more ticks from floor(2n/D2). A broken carry shows up as an upper half off by one on the first read after the low word wraps. A missed or spurious retry changes the busy length in multiples of three cycles and the retry count within that same read, and a torn value differs from the exact expected value by 2^32. A wrong scale in the conversion shows on the elapsed port one cycle after the stop strobe.

// File: rtl/stbc_pkg.sv
package stbc_pkg;
    parameter int CNT_W  = 64;
    parameter int HALF_W = CNT_W / 2;
    parameter int DIV_W  = 16;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_HI0,
        RD_LO,
        RD_HI1
    } rd_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tstamp_t;

    // ticks times doubled divider, halved
    function automatic logic [CNT_W-1:0] ticks_to_core(
        input logic [CNT_W-1:0] ticks,
        input logic [DIV_W-1:0] d2
    );
        logic [CNT_W+DIV_W-1:0] prod;
        prod = {{DIV_W{1'b0}}, ticks} * {{CNT_W{1'b0}}, d2};
        return prod[CNT_W:1];
    endfunction
endpackage

// File: rtl/stbc_prescaler.sv
module stbc_prescaler
    import stbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div2,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = acc + ACC_W'(2);
        tick = (sum >= {1'b0, div2});
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (tick)  acc <= sum - {1'b0, div2};
        else            acc <= sum;
    end

    // R2: accumulator stays below the divider while the divider is steady
    a_r2_acc_bound: assert property (@(posedge clk) disable iff (rst)
        (clr || div2 < DIV_W'(2) || !$stable(div2)) || (acc < {1'b0, div2}));

    // R2: with a divider of at least 2 ticks, two ticks never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && div2 >= DIV_W'(4)) |=> (!tick || !$stable(div2) || $past(clr)));
endmodule

// File: rtl/stbc_counter.sv
module stbc_counter
    import stbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output tstamp_t          cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt.lo <= cnt.lo + HALF_W'(1);
            if (&cnt.lo) cnt.hi <= cnt.hi + HALF_W'(1);
        end
    end

    // R3: carry into the upper half on wrap of the lower half
    a_r3_carry: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && (&cnt.lo)) |=> (cnt.lo == '0 && cnt.hi == $past(cnt.hi) + HALF_W'(1)));

    // R3: no wrap, upper half holds
    a_r3_hold_hi: assert property (@(posedge clk) disable iff (rst)
        (!load && !(tick && (&cnt.lo))) |=> (cnt.hi == $past(cnt.hi)));

    // R8: load takes the preload value
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/stbc_reader.sv
module stbc_reader
    import stbc_pkg::*;
#(
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  tstamp_t            cnt,
    output logic               ack,
    output logic               busy,
    output tstamp_t            data,
    output logic [RETRY_W-1:0] retries
);
    rd_state_e          state;
    logic [HALF_W-1:0]  hi_first;
    logic [HALF_W-1:0]  lo_samp;

    assign busy = (state != RD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            hi_first <= '0;
            lo_samp  <= '0;
            data     <= '0;
            ack      <= 1'b0;
            retries  <= '0;
        end else begin
            ack <= 1'b0;
            unique case (state)
                RD_IDLE: if (req) state <= RD_HI0;
                RD_HI0: begin
                    hi_first <= cnt.hi;
                    state    <= RD_LO;
                end
                RD_LO: begin
                    lo_samp <= cnt.lo;
                    state   <= RD_HI1;
                end
                RD_HI1: begin
                    if (cnt.hi == hi_first) begin
                        data  <= '{hi: hi_first, lo: lo_samp};
                        ack   <= 1'b1;
                        state <= RD_IDLE;
                    end else begin
                        if (!(&retries)) retries <= retries + RETRY_W'(1);
                        state <= RD_HI0;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // R4: acknowledge is a single-cycle pulse, given only when idle
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    a_r4_ack_idle: assert property (@(posedge clk) disable iff (rst)
        ack |-> !busy);

    // R5: mismatch of upper samples restarts the sequence with busy held
    a_r5_retry: assert property (@(posedge clk) disable iff (rst)
        (state == RD_HI1 && cnt.hi != hi_first) |=> (busy && state == RD_HI0));

    // R6: returned upper half equals the second upper sample
    a_r6_untorn: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> (data.hi == $past(cnt.hi)));

    // R7: saturated retry count stays saturated
    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (&retries) |=> (&retries));
endmodule

// File: rtl/split_timebase.sv
module split_timebase
    import stbc_pkg::*;
#(
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   div2,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               rd_req,
    output logic               rd_ack,
    output logic               rd_busy,
    output logic [CNT_W-1:0]   rd_data,
    output logic [RETRY_W-1:0] rd_retries,
    input  logic               cap_start,
    input  logic               cap_stop,
    output logic [CNT_W-1:0]   elapsed
);
    logic             tick;
    tstamp_t          cnt;
    tstamp_t          rd_word;
    logic [CNT_W-1:0] snap_a;
    logic [CNT_W-1:0] snap_b;

    stbc_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .div2 (div2),
        .tick (tick)
    );

    stbc_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .cnt      (cnt)
    );

    stbc_reader #(.RETRY_W(RETRY_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .req     (rd_req),
        .cnt     (cnt),
        .ack     (rd_ack),
        .busy    (rd_busy),
        .data    (rd_word),
        .retries (rd_retries)
    );

    assign rd_data = rd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_a <= '0;
            snap_b <= '0;
        end else begin
            if (cap_start) snap_a <= cnt;
            if (cap_stop)  snap_b <= cnt;
        end
    end

    assign elapsed = ticks_to_core(snap_b - snap_a, div2);

    // R9: start strobe captures the live counter
    a_r9_start_cap: assert property (@(posedge clk) disable iff (rst)
        cap_start |=> (snap_a == $past(cnt)));
    // R1: busy and acknowledge never overlap
    a_r1_ack_busy: assert property (@(posedge clk) disable iff (rst)
        !(rd_ack && rd_busy));
endmodule

// File: tb/split_timebase_bench.sv
`timescale 1ns/1ps
module split_timebase_bench;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   div2;
    logic          load;
    logic [63:0]   load_val;
    logic          rd_req;
    logic          rd_ack;
    logic          rd_busy;
    logic [63:0]   rd_data;
    logic [RW-1:0] rd_retries;
    logic          cap_start;
    logic          cap_stop;
    logic [63:0]   elapsed;

    int compared = 0;
    int mismatched = 0;
    int wd = 0;

    logic [63:0] n;
    logic [63:0] base;
    logic [15:0] d2;
    int          rexp;

    always #2.5 clk = ~clk;

    split_timebase #(.RETRY_W(RW)) u_split_timebase (
        .clk(clk), .rst(rst), .div2(div2), .load(load), .load_val(load_val),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_busy(rd_busy), .rd_data(rd_data),
        .rd_retries(rd_retries), .cap_start(cap_start), .cap_stop(cap_stop),
        .elapsed(elapsed)
    );

    // clocks since the last reset or load edge
    always @(posedge clk) begin
        if (rst || load) n <= 64'd0;
        else             n <= n + 64'd1;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", wd, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic logic [63:0] expc(input logic [63:0] k);
        logic [63:0] t;
        t = (k * 64'd2) / {48'd0, d2};
        return base + t;
    endfunction

    function automatic logic [63:0] exp_elapsed(input logic [63:0] a, input logic [63:0] b);
        logic [79:0] p;
        p = {16'd0, b - a} * {64'd0, d2};
        return p[64:1];
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic do_load(input logic [63:0] v, input logic [15:0] dv);
        d2 = dv; div2 = dv; base = v;
        load_val = v; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_read(output logic [63:0] d, output int bc, output logic [63:0] nreq);
        nreq = n;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        bc = 0;
        while (!rd_ack && bc < 60) begin
            if (rd_busy) bc++;
            @(negedge clk);
        end
        d = rd_data;
        check(rd_ack && !rd_busy, "R4 ack with busy low", {62'd0, rd_ack, rd_busy}, 64'd2);
    endtask

    // checks value, length and retry count of one read
    task automatic read_check(input string tag);
        logic [63:0] d, nq;
        int bc;
        int extra;
        do_read(d, bc, nq);
        check((bc % 3) == 0 && bc >= 3, {tag, " R5 busy length multiple of 3"},
              64'(bc), 64'd3);
        check(d == expc(nq + 64'(bc) - 64'd1), {tag, " R6 R2 exact value"},
              d, expc(nq + 64'(bc) - 64'd1));
        extra = bc / 3 - 1;
        rexp = (rexp + extra > 3) ? 3 : rexp + extra;
        check(rd_retries == RW'(rexp), {tag, " R7 retry count"},
              64'(rd_retries), 64'(rexp));
    endtask

    task automatic elapsed_check(input int g0, input int g1, input string tag);
        logic [63:0] sa, sb;
        repeat (g0) @(negedge clk);
        sa = expc(n);
        cap_start = 1'b1;
        @(negedge clk);
        cap_start = 1'b0;
        repeat (g1) @(negedge clk);
        sb = expc(n);
        cap_stop = 1'b1;
        @(negedge clk);
        cap_stop = 1'b0;
        check(elapsed == exp_elapsed(sa, sb), {tag, " R9 elapsed"}, elapsed, exp_elapsed(sa, sb));
    endtask

    initial begin
        logic [63:0] d, nq;
        int bc;
        void'($urandom(32'd1234));
        rst = 1'b1; div2 = 16'd4; d2 = 16'd4; base = 64'd0; rexp = 0;
        load = 1'b0; load_val = '0; rd_req = 1'b0; cap_start = 1'b0; cap_stop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: state after reset
        check(elapsed == 64'd0, "R1 elapsed zero", elapsed, 64'd0);
        check(!rd_busy && !rd_ack, "R1 idle", {62'd0, rd_busy, rd_ack}, 64'd0);
        check(rd_retries == '0, "R1 retries zero", 64'(rd_retries), 64'd0);

        // R4: plain read takes three busy cycles; R2 rate from reset
        do_read(d, bc, nq);
        check(bc == 3, "R4 busy three cycles", 64'(bc), 64'd3);
        check(d == expc(nq + 64'd2), "R2 value from reset", d, expc(nq + 64'd2));

        // R5 R7 R3: reads forced to straddle a low-word wrap, retry count saturates at 3
        for (int i = 0; i < 4; i++) begin
            do_load(64'h0000_0000_FFFF_FFFD + {32'(i), 32'd0}, 16'd2);
            do_read(d, bc, nq);
            check(bc == 6, "R5 one retry, six busy cycles", 64'(bc), 64'd6);
            check(d == expc(nq + 64'd5), "R3 R6 value after wrap", d, expc(nq + 64'd5));
            rexp = (rexp < 3) ? rexp + 1 : 3;
            check(rd_retries == RW'(rexp), "R7 retry count saturating",
                  64'(rd_retries), 64'(rexp));
        end

        // R8: load then immediate read, half-integer divider 2.5
        do_load(64'h0000_0000_FFFF_FFF0, 16'd5);
        read_check("R8 load");
        read_check("R2 half divider");
        elapsed_check(2, 7, "half divider");

        // random mix of dividers and preloads near the low-word wrap
        for (int i = 0; i < 40; i++) begin
            logic [63:0] v;
            v = {$urandom, 32'hFFFF_FFFF - ($urandom % 24)};
            do_load(v, 16'(2 + ($urandom % 9)));
            for (int j = 0; j < 3; j++) begin
                repeat ($urandom % 4) @(negedge clk);
                read_check("rand");
            end
            elapsed_check(int'($urandom % 5), int'($urandom % 30), "rand");
        end

        // R9: start and stop on the same edge give zero
        do_load(64'h1234, 16'd3);
        cap_start = 1'b1; cap_stop = 1'b1;
        @(negedge clk);
        cap_start = 1'b0; cap_stop = 1'b0;
        check(elapsed == 64'd0, "R9 same-edge capture", elapsed, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule